// File: doc/BRIEF.md
# Segmented Current-Steering DAC Code Decoder with Dynamic Element Matching

This block is the digital front end of a 12-bit segmented current-steering converter. On every sample clock it accepts a 12-bit code and divides it into two parts. The upper four bits become a count of unit current cells to switch on. Those cells are laid out as a 15-wide thermometer vector. The lower eight bits go straight to binary-weighted cells.

To spread out cell mismatch, a pseudo-random rotation moves the block of active unit cells around the 15-cell ring on each sample. The number of active cells does not change. The rotation comes from a free-running 16-bit LFSR, which is loaded from a seed input during reset. Clearing the shuffle enable stops the rotation and fills the cells from index 0 upward. Both segments pass through the same two register stages, so a code reaches the cell enables as one aligned word two clocks after it is applied.

The block has no state machine. It is a fixed two-stage pipeline: a capture stage holds the split code, its valid bit and the rotation chosen for it, and an output stage holds the rotated unary enables and the binary enables.

Top module: `seg_dac_decoder`

## Requirements
- R1: `binary_en` equals `in_code[7:0]` of the sample it belongs to. The unary segment is driven only by `in_code[11:8]`.
- R2: For every valid output word, the number of ones in `unary_en` equals the value of `in_code[11:8]` of that sample.
- R3: When `dem_en` was low with a sample, its `unary_en` is the plain thermometer: bits 0 up to M-1 set, where M is `in_code[11:8]`.
- R4: When `dem_en` was high with a sample, its `unary_en` is the plain thermometer rotated left by r positions within the 15-bit ring. Input bit i moves to bit (i+r) mod 15. Here r = (lfsr[7:0]) mod 15, and lfsr is the generator value at the clock edge that captures the sample.
- R5: While `rst` is high, the generator loads `seed`, or 16'hACE1 if `seed` is zero. After reset it advances on every clock as a left shift that brings in lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10] at bit 0, and it never becomes zero.
- R6: A sample applied before clock edge k appears on all outputs after edge k+1, and both segments change on that same edge.
- R7: During reset, and for any output slot whose sample had `in_vld` low, `out_vld` is low and all unary and binary enables are zero.
- R8: A code with upper nibble 0 gives all-zero unary enables, and one with upper nibble 15 gives all fifteen set, for any rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| dem_en | input | 1 | Enable for the unit-cell rotation, captured with each sample |
| seed | input | 16 | Generator seed, loaded while in reset |
| in_vld | input | 1 | Marks `in_code` as a valid sample |
| in_code | input | 12 | Input code: upper nibble unary, lower byte binary |
| out_vld | output | 1 | Output word is valid |
| unary_en | output | 15 | Unary unit-cell enables, rotated |
| binary_en | output | 8 | Binary-weighted cell enables |

## Verification
A change of the rotation enable can arrive on the same clock as a new code, and a sample marked invalid can sit between two valid ones. Each sample has to carry its own enable and valid flag through the pipeline without picking up its neighbour's. The bench flips `dem_en` and `in_vld` at random on each sample and models the generator cycle by cycle from the seed. It then compares each output word with the word predicted for the sample two edges earlier. Directed runs at nibble 0 and 15 with rotation on, plus a second reset with a zero seed, cover the boundary cases.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
    localparam int MSB_W    = 4;
    localparam int LSB_W    = 8;
    localparam int CODE_W   = MSB_W + LSB_W;
    localparam int UNARY_N  = (1 << MSB_W) - 1;
    localparam int ROT_W    = $clog2(UNARY_N);
    localparam int LFSR_W   = 16;
    localparam logic [LFSR_W-1:0] SEED_FALLBACK = 16'hACE1;

    typedef struct packed {
        logic             vld;
        logic [MSB_W-1:0] msb;
        logic [LSB_W-1:0] lsb;
        logic [ROT_W-1:0] rot;
    } cap_stage_t;
endpackage

// File: rtl/dem_lfsr.sv
module dem_lfsr #(
    parameter int W = 16,
    parameter logic [W-1:0] FALLBACK = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    logic fb;

    // taps for x^16 + x^14 + x^13 + x^11 + 1
    always_comb fb = state[W-1] ^ state[W-3] ^ state[W-4] ^ state[W-6];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= (seed == '0) ? FALLBACK : seed;
        end else begin
            state <= {state[W-2:0], fb};
        end
    end
endmodule

// File: rtl/therm_decoder.sv
module therm_decoder #(
    parameter int IN_W = 4,
    parameter int N    = 15
) (
    input  logic [IN_W-1:0] count,
    output logic [N-1:0]    therm
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        assign therm[i] = (int'(count) > i);
    end
endmodule

// File: rtl/ring_rotator.sv
module ring_rotator #(
    parameter int N     = 15,
    parameter int SEL_W = 4
) (
    input  logic [N-1:0]     din,
    input  logic [SEL_W-1:0] amount,
    output logic [N-1:0]     dout
);
    logic [N-1:0] stage [SEL_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SEL_W; k++) begin : g_stage
        localparam int SH = (1 << k) % N;
        logic [N-1:0] turned;
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign turned[(i + SH) % N] = stage[k][i];
        end
        assign stage[k+1] = amount[k] ? turned : stage[k];
    end

    assign dout = stage[SEL_W];
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
    import seg_dac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dem_en,
    input  logic [LFSR_W-1:0] seed,
    input  logic              in_vld,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_vld,
    output logic [UNARY_N-1:0] unary_en,
    output logic [LSB_W-1:0]  binary_en
);
    logic [LFSR_W-1:0]  lfsr_q;
    logic [ROT_W-1:0]   rot_pick;
    cap_stage_t         cap_q;
    logic [UNARY_N-1:0] therm_vec;
    logic [UNARY_N-1:0] turned_vec;

    dem_lfsr #(
        .W        (LFSR_W),
        .FALLBACK (SEED_FALLBACK)
    ) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .seed  (seed),
        .state (lfsr_q)
    );

    always_comb begin
        rot_pick = '0;
        if (dem_en) begin
            rot_pick = ROT_W'(lfsr_q[7:0] % UNARY_N);
        end
    end

    // capture stage: split code, valid and rotation travel together
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.vld <= in_vld;
            cap_q.msb <= in_vld ? in_code[CODE_W-1:LSB_W] : '0;
            cap_q.lsb <= in_vld ? in_code[LSB_W-1:0] : '0;
            cap_q.rot <= rot_pick;
        end
    end

    therm_decoder #(
        .IN_W (MSB_W),
        .N    (UNARY_N)
    ) u_therm (
        .count (cap_q.msb),
        .therm (therm_vec)
    );

    ring_rotator #(
        .N     (UNARY_N),
        .SEL_W (ROT_W)
    ) u_rot (
        .din    (therm_vec),
        .amount (cap_q.rot),
        .dout   (turned_vec)
    );

    // output stage: both segments updated on one edge
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld   <= 1'b0;
            unary_en  <= '0;
            binary_en <= '0;
        end else begin
            out_vld   <= cap_q.vld;
            unary_en  <= cap_q.vld ? turned_vec : '0;
            binary_en <= cap_q.vld ? cap_q.lsb : '0;
        end
    end
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk
    import seg_dac_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               dem_en,
    input logic               in_vld,
    input logic [CODE_W-1:0]  in_code,
    input logic               out_vld,
    input logic [UNARY_N-1:0] unary_en,
    input logic [LSB_W-1:0]   binary_en,
    input logic [LFSR_W-1:0]  lfsr_state
);
    // R2
    pop_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ($countones(unary_en) == int'($past(in_code[CODE_W-1:LSB_W], 2))));

    // R1
    lsb_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (binary_en == $past(in_code[LSB_W-1:0], 2)));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (unary_en == '0 && binary_en == '0));

    // R3
    plain_therm_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !$past(dem_en, 2)) |->
        (unary_en == UNARY_N'((16'd1 << $past(in_code[CODE_W-1:LSB_W], 2)) - 16'd1)));

    // R5
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);

    // R6
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld, 2));
endmodule

bind seg_dac_decoder seg_dac_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dem_en     (dem_en),
    .in_vld     (in_vld),
    .in_code    (in_code),
    .out_vld    (out_vld),
    .unary_en   (unary_en),
    .binary_en  (binary_en),
    .lfsr_state (lfsr_q)
);

// File: tb/seg_dac_decoder_test.sv
module seg_dac_decoder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        dem_en;
    logic [15:0] seed;
    logic        in_vld;
    logic [11:0] in_code;
    logic        out_vld;
    logic [14:0] unary_en;
    logic [7:0]  binary_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_lfsr;
    logic        p_vld;
    logic [14:0] p_u;
    logic [7:0]  p_b;
    logic        p_dem;

    always #4 clk = ~clk;

    seg_dac_decoder uut (
        .clk(clk), .rst(rst), .dem_en(dem_en), .seed(seed),
        .in_vld(in_vld), .in_code(in_code), .out_vld(out_vld),
        .unary_en(unary_en), .binary_en(binary_en)
    );

    function automatic logic [15:0] lfsr_next(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [14:0] therm_of(int m);
        logic [14:0] t = '0;
        for (int i = 0; i < m; i++) t[i] = 1'b1;
        return t;
    endfunction

    function automatic logic [14:0] rotl15(logic [14:0] x, int r);
        logic [14:0] y = '0;
        for (int i = 0; i < 15; i++) y[(i + r) % 15] = x[i];
        return y;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [15:0] s);
        @(negedge clk);
        rst = 1'b1; seed = s; in_vld = 1'b1; in_code = 12'hFFF; dem_en = 1'b1;
        repeat (3) @(negedge clk);
        // R7: outputs stay zero while in reset
        check(out_vld == 1'b0 && unary_en == '0 && binary_en == '0, "R7",
              {out_vld, unary_en, binary_en}, 32'd0);
        rst = 1'b0;
        m_lfsr = (s == 16'h0) ? 16'hACE1 : s;   // R5 reload rule
        p_vld = 1'b0; p_u = '0; p_b = '0; p_dem = 1'b0;
    endtask

    // one sample: drive at negedge, check previous sample after next edges (R6)
    task automatic step(logic v, logic [11:0] code, logic de);
        logic [14:0] eu;
        int r;
        in_vld = v; in_code = code; dem_en = de;
        r  = de ? int'(m_lfsr[7:0]) % 15 : 0;
        eu = v ? rotl15(therm_of(int'(code[11:8])), r) : '0;
        @(posedge clk);
        m_lfsr = lfsr_next(m_lfsr);
        @(negedge clk);
        // R6 alignment: output now holds the sample driven one step earlier
        check(out_vld == p_vld, "R7", 32'(out_vld), 32'(p_vld));
        check(unary_en == p_u, p_dem ? "R4" : "R3", 32'(unary_en), 32'(p_u));
        check(binary_en == p_b, "R1", 32'(binary_en), 32'(p_b));
        if (p_vld)
            check($countones(unary_en) == $countones(p_u), "R2",
                  32'($countones(unary_en)), 32'($countones(p_u)));
        p_vld = v; p_u = eu; p_b = v ? code[7:0] : '0; p_dem = de;
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; seed = 16'h1D2B; in_vld = 1'b0; in_code = '0; dem_en = 1'b0;
        do_reset(16'h1D2B);

        // R3: plain thermometer, every nibble value
        for (int m = 0; m < 16; m++) step(1'b1, {m[3:0], 8'(m * 17)}, 1'b0);
        // R8: extremes with rotation active
        for (int i = 0; i < 20; i++) step(1'b1, {(i % 2 == 0) ? 4'h0 : 4'hF, 8'(i)}, 1'b1);
        // R7: invalid gap between valid samples
        step(1'b1, 12'hA5C, 1'b1);
        step(1'b0, 12'h7FF, 1'b1);
        step(1'b1, 12'h3C3, 1'b0);
        // R4 / R2 / R1: random mix including dem_en and valid toggles
        for (int i = 0; i < 600; i++)
            step(($urandom % 8) != 0, 12'($urandom), 1'($urandom));
        step(1'b0, 12'h000, 1'b0);

        // R5: zero seed falls back to the fixed value
        do_reset(16'h0000);
        for (int i = 0; i < 200; i++)
            step(($urandom % 6) != 0, 12'($urandom), 1'b1);
        step(1'b0, 12'h000, 1'b0);
        step(1'b0, 12'h000, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule